// File: doc/BRIEF.md
# I2C Write-Only Target with Address-Phase Clock Hold

This block is an I2C target that only accepts data: a bus controller addresses it with the write direction and then sends bytes, which the block acknowledges and hands to software one at a time. It observes the open-drain clock and data wires through its inputs. It pulls either wire low through an output-enable, and the board's open-drain pads do the rest.

Software programs the block through a small byte-wide register port. The port holds the 7-bit address the block answers to, an enable, a hold-off option and an interrupt enable for address hits. Software reads a status word, fetches received bytes, and clears flags by writing ones to a clear register. By default the block keeps the clock low after acknowledging its address until software clears the address-hit flag. This lets software prepare before the first data byte moves. The block also keeps the clock low when a new byte arrives while the previous one is still unread. With the hold-off option set, the block never holds the clock and reception runs freely.

Register offsets on `regAddr`:
- 0 is control, read/write. Bit 0 is enable, bit 1 is the hold-off option, and bit 2 is the address interrupt enable.
- 1 is the own address in bits 6:0.
- 2 is status, read-only. Bit 0 is bus busy, bit 1 is address hit, bit 2 is byte ready, and bit 3 is stop seen.
- 3 is the write-1-to-clear register. Bit 1 clears address hit and bit 3 clears stop seen.
- 4 is received data, and reading it with `regRdEn` consumes the byte.

Top module: `i2c_target_rx`

## Requirements
- R1: After reset all status bits are 0, `sclOe`, `sdaOe` and `irq` are 0, and control reads 0.
- R2: Status bit 0 (busy) becomes 1 after a START (SDA falls while SCL is high) and returns to 0 after a STOP (SDA rises while SCL is high).
- R3: While control bit 0 is 0, busy reads 0 and the block drives neither wire; clearing bit 0 during a transfer drops busy at once.
- R4: An address byte whose upper 7 bits equal the own address and whose last bit is 0 is acknowledged (SDA low on the ninth clock) and sets status bit 1; `irq` equals status bit 1 AND control bit 2.
- R5: An address byte that differs from the own address, or has its last bit 1, is not acknowledged and sets no flag; the bytes that follow until the next START are neither acknowledged nor stored.
- R6: With control bit 1 at 0, after the address acknowledge `sclOe` stays 1 for as long as status bit 1 is set; writing 1 to bit 1 of the clear register releases it.
- R7: With control bit 1 at 1, `sclOe` stays 0 after an address hit, and a data byte is received and acknowledged while status bit 1 is still set.
- R8: Each data byte of an addressed transfer is acknowledged, sets status bit 2 and appears at offset 4, most significant bit first; a read of offset 4 clears status bit 2.
- R9: With control bit 1 at 0, if status bit 2 is still set when the eighth bit of a new byte has been clocked, `sclOe` is held at 1 until offset 4 is read; the new byte is then stored and acknowledged.
- R10: A STOP that ends an addressed transfer sets status bit 3; writing 1 to bit 3 of the clear register clears it.
- R11: A repeated START followed by a matching address sets status bit 1 again and holds the clock under the same rule as R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Level seen on the SCL wire |
| sdaIn | input | 1 | Level seen on the SDA wire |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on offset 4) |
| regAddr | input | 3 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regAddr |
| irq | output | 1 | Address-hit interrupt request |

## Verification
The assertions assume that SCL and SDA change only at speeds the two-flop synchronizers can follow. They also assume that SDA moves only while SCL is low, except when the controller deliberately forms a START or STOP. The bench's controller model meets both assumptions: each SCL phase lasts eight system clocks, and SDA is set up a full phase before the clock rises. After releasing SCL, the model waits until the wire actually reads high. Because of this, the clock holds of R6, R9 and R11 pause it instead of corrupting a bit. Register strobes are driven one cycle at a time on the falling clock edge, away from the sampling edge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;
  localparam int REG_AW = 3;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_OWN   = 3'd1;
  localparam logic [REG_AW-1:0] OFF_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] OFF_CLR   = 3'd3;
  localparam logic [REG_AW-1:0] OFF_RXDAT = 3'd4;

  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
  } busEvt_t;

  typedef struct packed {
    logic shiftEn;
    logic loadRx;
    logic setAddr;
    logic setStop;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_AHOLD, ST_DATA, ST_RXWAIT, ST_DACK, ST_IGNORE
  } rxState_t;
endpackage

// File: rtl/i2c_rx_datapath.sv
module i2c_rx_datapath
  import i2c_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  input  ctrlStrobes_t       strobes,
  output busEvt_t            evt,
  output logic               addrMatch,
  output logic               addrFlag,
  output logic               rxFull,
  output logic               stopFlag,
  output logic               busy,
  output logic               cfgEnable,
  output logic               cfgNoStretch,
  output logic               cfgIrqEn,
  output logic [DATA_W-1:0]  regRdata
);
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic [DATA_W-1:0] shiftReg, rxData;
  logic [ADDR_W-1:0] ownAddr;
  logic wrCtrl, wrOwn, wrClr, rdRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  always_comb begin
    evt.start   = cfgEnable && sclSync[1] && sclPrev && sdaPrev && !sdaSync[1];
    evt.stop    = cfgEnable && sclSync[1] && sclPrev && !sdaPrev && sdaSync[1];
    evt.sclRise = cfgEnable && sclSync[1] && !sclPrev;
    evt.sclFall = cfgEnable && !sclSync[1] && sclPrev;
  end

  assign addrMatch = (shiftReg[DATA_W-1:1] == ownAddr) && !shiftReg[0];

  assign wrCtrl = regWrEn && (regAddr == OFF_CTRL);
  assign wrOwn  = regWrEn && (regAddr == OFF_OWN);
  assign wrClr  = regWrEn && (regAddr == OFF_CLR);
  assign rdRx   = regRdEn && (regAddr == OFF_RXDAT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable    <= 1'b0;
      cfgNoStretch <= 1'b0;
      cfgIrqEn     <= 1'b0;
      ownAddr      <= '0;
    end else begin
      if (wrCtrl) {cfgIrqEn, cfgNoStretch, cfgEnable} <= regWdata[2:0];
      if (wrOwn)  ownAddr <= regWdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      addrFlag <= 1'b0;
      rxFull   <= 1'b0;
      stopFlag <= 1'b0;
      busy     <= 1'b0;
    end else begin
      if (strobes.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], sdaSync[1]};
      if (strobes.loadRx)  rxData <= shiftReg;

      if (strobes.setAddr)                addrFlag <= 1'b1;
      else if (wrClr && regWdata[1])      addrFlag <= 1'b0;

      if (strobes.loadRx)                 rxFull <= 1'b1;
      else if (rdRx)                      rxFull <= 1'b0;

      if (strobes.setStop)                stopFlag <= 1'b1;
      else if (wrClr && regWdata[3])      stopFlag <= 1'b0;

      if (!cfgEnable)                     busy <= 1'b0;
      else if (evt.start)                 busy <= 1'b1;
      else if (evt.stop)                  busy <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFF_CTRL:  regRdata[2:0] = {cfgIrqEn, cfgNoStretch, cfgEnable};
      OFF_OWN:   regRdata[ADDR_W-1:0] = ownAddr;
      OFF_STAT:  regRdata[3:0] = {stopFlag, rxFull, addrFlag, busy};
      OFF_RXDAT: regRdata = rxData;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         noStretch,
  input  busEvt_t      evt,
  input  logic         addrMatch,
  input  logic         addrFlag,
  input  logic         rxFull,
  output ctrlStrobes_t strobes,
  output logic         sclOe,
  output logic         sdaOe
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  rxState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic byteEnd, rxBlocked;

  assign byteEnd   = evt.sclFall && (bitCnt == CNT_FULL);
  assign rxBlocked = rxFull && !noStretch;

  always_comb begin
    strobes.shiftEn = ((state == ST_ADDR) || (state == ST_DATA))
                      && evt.sclRise && (bitCnt < CNT_FULL);
    strobes.setAddr = (state == ST_ADDR) && byteEnd && addrMatch;
    strobes.loadRx  = ((state == ST_DATA) && byteEnd && !rxBlocked)
                      || ((state == ST_RXWAIT) && enable && !rxFull);
    strobes.setStop = evt.stop && ((state == ST_AACK) || (state == ST_AHOLD)
                      || (state == ST_DATA) || (state == ST_RXWAIT) || (state == ST_DACK));
  end

  assign sdaOe = (state == ST_AACK) || (state == ST_DACK);
  assign sclOe = (state == ST_AHOLD) || (state == ST_RXWAIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (!enable) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else if (evt.start) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (evt.stop) begin
      state  <= ST_IDLE;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (strobes.shiftEn) bitCnt <= bitCnt + 1'b1;
          else if (byteEnd)    state <= addrMatch ? ST_AACK : ST_IGNORE;
        end
        ST_AACK: if (evt.sclFall) begin
          bitCnt <= '0;
          state  <= (!noStretch && addrFlag) ? ST_AHOLD : ST_DATA;
        end
        ST_AHOLD: if (!addrFlag || noStretch) state <= ST_DATA;
        ST_DATA: begin
          if (strobes.shiftEn) bitCnt <= bitCnt + 1'b1;
          else if (byteEnd)    state <= rxBlocked ? ST_RXWAIT : ST_DACK;
        end
        ST_RXWAIT: if (!rxFull) state <= ST_DACK;
        ST_DACK: if (evt.sclFall) begin
          bitCnt <= '0;
          state  <= ST_DATA;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2c_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);
  busEvt_t      evt;
  ctrlStrobes_t strobes;
  logic addrMatch, addrFlag, rxFull, stopFlag, busy;
  logic cfgEnable, cfgNoStretch, cfgIrqEn;

  i2c_rx_datapath u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata),
    .strobes(strobes), .evt(evt), .addrMatch(addrMatch), .addrFlag(addrFlag),
    .rxFull(rxFull), .stopFlag(stopFlag), .busy(busy), .cfgEnable(cfgEnable),
    .cfgNoStretch(cfgNoStretch), .cfgIrqEn(cfgIrqEn), .regRdata(regRdata)
  );

  i2c_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(cfgEnable), .noStretch(cfgNoStretch),
    .evt(evt), .addrMatch(addrMatch), .addrFlag(addrFlag), .rxFull(rxFull),
    .strobes(strobes), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign irq = addrFlag && cfgIrqEn;
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker
  import i2c_rx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              cfgNoStretch,
  input logic              busy,
  input logic              addrFlag,
  input logic              rxFull,
  input logic              sclOe,
  input logic              sdaOe,
  input ctrlStrobes_t      strobes,
  input logic              regRdEn,
  input logic [REG_AW-1:0] regAddr
);
  AST_DISABLED_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> !busy); // R3

  AST_ADDR_HIT_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setAddr |=> addrFlag); // R4

  AST_HOLD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> $past(addrFlag || rxFull)); // R6

  AST_NO_HOLD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgNoStretch && $past(cfgNoStretch)) |-> !sclOe); // R7

  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && (regAddr == OFF_RXDAT) && !strobes.loadRx) |=> !rxFull); // R8

  AST_NO_LOAD_OVER_UNREAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadRx |-> (!rxFull || cfgNoStretch)); // R9

  AST_HOLD_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rstN)
    !(sclOe && sdaOe)); // R6
endmodule

bind i2c_target_rx i2c_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgNoStretch(cfgNoStretch),
  .busy(busy), .addrFlag(addrFlag), .rxFull(rxFull), .sclOe(sclOe), .sdaOe(sdaOe),
  .strobes(strobes), .regRdEn(regRdEn), .regAddr(regAddr)
);

// File: tb/test_i2c_target_rx.sv
module test_i2c_target_rx;
  localparam int HALF = 8;
  localparam int NVEC = 6;
  // {noStretch, expectAck, ownAddr[6:0], addrByte[7:0], dataByte[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 7'h42, 8'h84, 8'hA5},
    {1'b1, 1'b1, 7'h42, 8'h84, 8'h3C},
    {1'b0, 1'b1, 7'h11, 8'h22, 8'hFF},
    {1'b0, 1'b0, 7'h42, 8'h86, 8'h00},
    {1'b0, 1'b0, 7'h42, 8'h85, 8'h55},
    {1'b1, 1'b1, 7'h7F, 8'hFE, 8'h01}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, irq;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic sclIn, sdaIn;
  int total = 0, failed = 0, cycles = 0;
  logic doneFlag = 1'b0;

  assign sclIn = mScl & ~sclOe;
  assign sdaIn = mSda & ~sdaOe;

  always #4 clk = ~clk;

  i2c_target_rx i_i2c_target_rx (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdata;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic waitSclHigh();
    while (sclIn !== 1'b1) @(negedge clk);
  endtask

  task automatic mStart();
    mSda = 1'b1; mScl = 1'b1; waitCyc(HALF);
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b0; waitCyc(HALF);
  endtask

  task automatic mRestart();
    mSda = 1'b1; waitCyc(HALF);
    mScl = 1'b1; waitSclHigh(); waitCyc(HALF);
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b0; waitCyc(HALF);
  endtask

  task automatic mStop();
    mSda = 1'b0; waitCyc(HALF);
    mScl = 1'b1; waitSclHigh(); waitCyc(HALF);
    mSda = 1'b1; waitCyc(HALF);
  endtask

  task automatic mByte(input logic [7:0] b, output logic ackLevel);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitCyc(HALF);
      mScl = 1'b1; waitSclHigh(); waitCyc(HALF);
      mScl = 1'b0;
    end
    mSda = 1'b1; waitCyc(HALF);
    mScl = 1'b1; waitSclHigh(); waitCyc(HALF / 2);
    ackLevel = sdaIn; waitCyc(HALF / 2);
    mScl = 1'b0; waitCyc(HALF);
  endtask

  initial begin
    while (!doneFlag) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failed++; total++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] st, rd;
    logic ack, ack2;
    waitCyc(3); rstN = 1'b1; waitCyc(2);

    // R1 reset state
    regRead(3'd2, st); check("R1 status", st, 8'h00);
    regRead(3'd0, rd); check("R1 control", rd, 8'h00);
    check("R1 outputs", {5'b0, sclOe, sdaOe, irq}, 8'h00);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic ns, ea;
      logic [6:0] own;
      logic [7:0] ab, db;
      {ns, ea, own, ab, db} = VEC[v];
      regWrite(3'd1, {1'b0, own});
      regWrite(3'd0, {5'b0, 1'b1, ns, 1'b1});
      mStart(); waitCyc(2);
      regRead(3'd2, st); check("R2 busy after start", {7'b0, st[0]}, 8'h01);
      mByte(ab, ack);
      check("R4/R5 address ack level", {7'b0, ack}, {7'b0, ~ea});
      regRead(3'd2, st); check("R4/R5 addr flag", {7'b0, st[1]}, {7'b0, ea});
      check("R4 irq", {7'b0, irq}, {7'b0, ea});
      if (ea && !ns) begin
        check("R6 hold after address", {7'b0, sclOe}, 8'h01);
        waitCyc(20);
        check("R6 hold persists", {7'b0, sclOe}, 8'h01);
        regWrite(3'd3, 8'h02); waitCyc(3);
        check("R6 release on clear", {7'b0, sclOe}, 8'h00);
      end else if (ea) begin
        check("R7 no hold", {7'b0, sclOe}, 8'h00);
      end
      mByte(db, ack);
      check("R8/R5 data ack level", {7'b0, ack}, {7'b0, ~ea});
      regRead(3'd2, st); check("R8/R5 byte ready", {7'b0, st[2]}, {7'b0, ea});
      if (ea && ns) begin
        check("R7 addr flag still set", {7'b0, st[1]}, 8'h01);
        regWrite(3'd3, 8'h02);
      end
      mStop(); waitCyc(3);
      regRead(3'd2, st);
      check("R2 busy after stop", {7'b0, st[0]}, 8'h00);
      check("R10/R5 stop flag", {7'b0, st[3]}, {7'b0, ea});
      if (ea) begin
        regRead(3'd4, rd); check("R8 data", rd, db);
        regRead(3'd2, st); check("R8 read clears ready", {7'b0, st[2]}, 8'h00);
      end
      regWrite(3'd3, 8'h08);
      regRead(3'd2, st); check("R10 stop flag cleared", {7'b0, st[3]}, 8'h00);
    end

    // R3 disable mid-transfer
    regWrite(3'd1, 8'h42);
    regWrite(3'd0, 8'h01);
    mStart(); waitCyc(2);
    regRead(3'd2, st); check("R3 busy before disable", {7'b0, st[0]}, 8'h01);
    regWrite(3'd0, 8'h00);
    regRead(3'd2, st); check("R3 busy dropped", {7'b0, st[0]}, 8'h00);
    mByte(8'h84, ack);
    check("R3 no ack while disabled", {7'b0, ack}, 8'h01);
    check("R3 wires released", {6'b0, sclOe, sdaOe}, 8'h00);
    mStop(); waitCyc(3);

    // R9 unread byte holds the next one
    regWrite(3'd0, 8'h01);
    mStart();
    mByte(8'h84, ack);
    check("R4 irq masked", {7'b0, irq}, 8'h00);
    regWrite(3'd3, 8'h02); waitCyc(3);
    mByte(8'h11, ack);
    check("R9 first byte ack", {7'b0, ack}, 8'h00);
    fork
      mByte(8'h22, ack2);
      begin
        while (sclOe !== 1'b1) @(negedge clk);
        waitCyc(30);
        check("R9 hold while unread", {7'b0, sclOe}, 8'h01);
        regRead(3'd4, rd); check("R9 first byte data", rd, 8'h11);
      end
    join
    check("R9 second byte ack", {7'b0, ack2}, 8'h00);
    regRead(3'd4, rd); check("R9 second byte data", rd, 8'h22);

    // R11 repeated start re-addresses
    mRestart();
    mByte(8'h84, ack);
    check("R11 address ack", {7'b0, ack}, 8'h00);
    regRead(3'd2, st); check("R11 addr flag again", {7'b0, st[1]}, 8'h01);
    check("R11 hold again", {7'b0, sclOe}, 8'h01);
    regWrite(3'd3, 8'h02); waitCyc(3);
    check("R11 released", {7'b0, sclOe}, 8'h00);
    mStop(); waitCyc(3);
    regWrite(3'd3, 8'h08);

    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule